// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit takes one instruction operand request and turns it into an operand value. It reads a 3-bit mode code and decides where the value lives. The value may be the request's own field, a register, or a memory word. A memory word is reached through an address that the unit computes and then reads, once or twice. The computed effective address is reported next to the value. It is zero for the modes that have no address.

The register file is presented as a flattened vector of eight 32-bit words, and the stack pointer is a plain input. Memory is reached through a read port with a request, an acknowledge and a variable response time. The unit accepts a request only while it is not busy. It signals completion with a single-cycle `done` strobe, and the operand, effective address and illegal flag are valid while that strobe is high.

Top module: `opf_unit`

## Requirements
- R1: Mode code 0 (immediate): the operand equals `req_field`, the effective address is 0, and no memory read is made. `done` rises in the cycle after acceptance.
- R2: Mode code 1 (direct): exactly one memory read is made at address `req_field`. The operand is the returned word, and the effective address is `req_field`.
- R3: Mode code 2 (indirect): a first read at `req_field` returns a pointer, and a second read is then made at that pointer. The operand is the second returned word, and the effective address is the pointer.
- R4: Mode code 3 (register): the operand is register `req_reg`, the effective address is 0, and no memory read is made. `done` rises in the cycle after acceptance.
- R5: Mode code 4 (register-indirect): one read is made at the content of register `req_reg`. That content is also the effective address.
- R6: Mode code 5 (displacement): the effective address is reg[`req_reg`] + (reg[`req_index`] << `req_scale`) + displacement. The scale codes 0 to 3 multiply the index by 1, 2, 4 and 8. One read at that address supplies the operand.
- R7: In displacement mode, `req_wide` = 1 uses all 32 bits of `req_field` as the displacement. `req_wide` = 0 uses `req_field[7:0]` sign-extended to 32 bits.
- R8: Mode code 6 (stack): one read is made at `stack_ptr`. The operand is the returned word, and the effective address is `stack_ptr`.
- R9: Mode code 7 is illegal. It completes in the cycle after acceptance with `illegal` = 1, operand 0 and effective address 0, and no memory read is made.
- R10: Once raised, `mem_req` and `mem_addr` stay unchanged until a cycle with `mem_ack` high, for any number of wait cycles.
- R11: A request is accepted only when `busy` is 0. `busy` is 1 from acceptance through the `done` cycle. A `req_valid` given while busy is ignored and produces no result.
- R12: `done` is high for exactly one cycle per accepted request. After reset, `done`, `mem_req` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 3 | Addressing-mode code, 0 to 7 |
| req_reg | input | 3 | Register selector, or base register in displacement mode |
| req_index | input | 3 | Index register in displacement mode |
| req_scale | input | 2 | Index shift amount in displacement mode |
| req_wide | input | 1 | 1 selects a 32-bit displacement, 0 selects an 8-bit one |
| req_field | input | 32 | Immediate value, address or displacement |
| reg_file | input | 256 | Register i occupies bits [32*i+31 : 32*i] |
| stack_ptr | input | 32 | Top-of-stack address |
| busy | output | 1 | Unit cannot accept a request |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion strobe |
| operand | output | 32 | Resolved operand |
| eff_addr | output | 32 | Effective address (0 when none) |
| illegal | output | 1 | Illegal mode code, valid with done |

## Verification
Every mode code is issued, and the operand, effective address and number of memory reads are compared for each. This separates the no-read, single-read and chained-read paths. Displacement requests combine different base and index registers with all four scales and with both displacement widths. Narrow displacements carry nonzero high field bits and a negative low byte, so a missing shift or a missing sign extension gives a wrong address. Memory wait counts from zero to several cycles test that the request is held. A request pulsed while busy tests that it leaves no trace in the results.

// File: rtl/opf_pkg.sv
package opf_pkg;
    localparam int DATA_W       = 32;
    localparam int REG_COUNT    = 8;
    localparam int SEL_W        = $clog2(REG_COUNT);
    localparam int SCALE_W      = 2;
    localparam int SHORT_DISP_W = 8;
    localparam int MODE_W       = 3;

    typedef enum logic [MODE_W-1:0] {
        OPM_IMM  = 3'd0,
        OPM_DIR  = 3'd1,
        OPM_IND  = 3'd2,
        OPM_REG  = 3'd3,
        OPM_RIND = 3'd4,
        OPM_DISP = 3'd5,
        OPM_STK  = 3'd6,
        OPM_BAD  = 3'd7
    } opmode_e;

    typedef struct packed {
        logic              reads_mem;
        logic              chained;
        logic              bad;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] value;
    } fetch_plan_t;

    function automatic logic [DATA_W-1:0] widen_disp(logic [DATA_W-1:0] f, logic wide);
        return wide ? f : {{(DATA_W-SHORT_DISP_W){f[SHORT_DISP_W-1]}}, f[SHORT_DISP_W-1:0]};
    endfunction

    function automatic logic [DATA_W-1:0] scaled_sum(logic [DATA_W-1:0] base,
                                                     logic [DATA_W-1:0] idx,
                                                     logic [SCALE_W-1:0] sc,
                                                     logic [DATA_W-1:0] disp);
        return base + (idx << sc) + disp;
    endfunction
endpackage

// File: rtl/opf_reg_port.sv
module opf_reg_port #(
    parameter int NREG = opf_pkg::REG_COUNT,
    parameter int DW   = opf_pkg::DATA_W,
    localparam int SW  = $clog2(NREG)
) (
    input  logic [NREG*DW-1:0] regs_flat,
    input  logic [SW-1:0]      sel,
    output logic [DW-1:0]      data
);
    logic [DW-1:0] words [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        assign words[g] = regs_flat[g*DW +: DW];
    end

    assign data = words[sel];
endmodule

// File: rtl/opf_ea_plan.sv
module opf_ea_plan
    import opf_pkg::*;
(
    input  opmode_e             mode,
    input  logic [DATA_W-1:0]   field,
    input  logic                wide,
    input  logic [SCALE_W-1:0]  scale,
    input  logic [DATA_W-1:0]   reg_a,
    input  logic [DATA_W-1:0]   reg_b,
    input  logic [DATA_W-1:0]   sp,
    output fetch_plan_t         plan
);
    always_comb begin
        plan = '0;
        unique case (mode)
            OPM_IMM:  plan.value = field;
            OPM_DIR:  begin plan.reads_mem = 1'b1; plan.addr = field; end
            OPM_IND:  begin plan.reads_mem = 1'b1; plan.chained = 1'b1; plan.addr = field; end
            OPM_REG:  plan.value = reg_a;
            OPM_RIND: begin plan.reads_mem = 1'b1; plan.addr = reg_a; end
            OPM_DISP: begin
                plan.reads_mem = 1'b1;
                plan.addr = scaled_sum(reg_a, reg_b, scale, widen_disp(field, wide));
            end
            OPM_STK:  begin plan.reads_mem = 1'b1; plan.addr = sp; end
            default:  plan.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/opf_mem_seq.sv
module opf_mem_seq
    import opf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  fetch_plan_t       plan,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] eff_addr,
    output logic              illegal,
    output logic              busy
);
    typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} seq_state_e;

    seq_state_e state;
    logic       chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            chain_q  <= 1'b0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            operand  <= '0;
            eff_addr <= '0;
            illegal  <= 1'b0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        eff_addr <= plan.addr;
                        if (plan.reads_mem) begin
                            mem_req  <= 1'b1;
                            mem_addr <= plan.addr;
                            chain_q  <= plan.chained;
                            state    <= S_FIRST;
                        end else begin
                            operand <= plan.value;
                            illegal <= plan.bad;
                            done    <= 1'b1;
                        end
                    end
                end
                S_FIRST: begin
                    if (mem_ack) begin
                        if (chain_q) begin
                            mem_addr <= mem_rdata;
                            eff_addr <= mem_rdata;
                            state    <= S_SECOND;
                        end else begin
                            mem_req <= 1'b0;
                            operand <= mem_rdata;
                            done    <= 1'b1;
                            state   <= S_IDLE;
                        end
                    end
                end
                default: begin
                    if (mem_ack) begin
                        mem_req <= 1'b0;
                        operand <= mem_rdata;
                        done    <= 1'b1;
                        state   <= S_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy = (state != S_IDLE) || done;
endmodule

// File: rtl/opf_unit.sv
module opf_unit
    import opf_pkg::*;
#(
    parameter int NREG = REG_COUNT,
    localparam int SW  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [MODE_W-1:0]      req_mode,
    input  logic [SW-1:0]          req_reg,
    input  logic [SW-1:0]          req_index,
    input  logic [SCALE_W-1:0]     req_scale,
    input  logic                   req_wide,
    input  logic [DATA_W-1:0]      req_field,
    input  logic [NREG*DATA_W-1:0] reg_file,
    input  logic [DATA_W-1:0]      stack_ptr,
    output logic                   busy,
    output logic                   mem_req,
    output logic [DATA_W-1:0]      mem_addr,
    input  logic                   mem_ack,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   done,
    output logic [DATA_W-1:0]      operand,
    output logic [DATA_W-1:0]      eff_addr,
    output logic                   illegal
);
    logic [DATA_W-1:0] reg_a;
    logic [DATA_W-1:0] reg_b;
    fetch_plan_t       plan;
    logic              accept;

    assign accept = req_valid && !busy;

    opf_reg_port #(.NREG(NREG), .DW(DATA_W)) i_port_a (
        .regs_flat (reg_file),
        .sel       (req_reg),
        .data      (reg_a)
    );

    opf_reg_port #(.NREG(NREG), .DW(DATA_W)) i_port_b (
        .regs_flat (reg_file),
        .sel       (req_index),
        .data      (reg_b)
    );

    opf_ea_plan i_plan (
        .mode  (opmode_e'(req_mode)),
        .field (req_field),
        .wide  (req_wide),
        .scale (req_scale),
        .reg_a (reg_a),
        .reg_b (reg_b),
        .sp    (stack_ptr),
        .plan  (plan)
    );

    opf_mem_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .plan      (plan),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .done      (done),
        .operand   (operand),
        .eff_addr  (eff_addr),
        .illegal   (illegal),
        .busy      (busy)
    );
endmodule

// File: rtl/opf_unit_chk.sv
module opf_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_mode,
    input logic [31:0] req_field,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic [31:0] eff_addr,
    input logic        illegal
);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R1, R4, R9: modes without a memory reference finish at once
    p_noread_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_mode == 3'd0 || req_mode == 3'd3 || req_mode == 3'd7))
        |=> (done && !mem_req));

    p_direct_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_mode == 3'd1)
        |=> (mem_req && mem_addr == $past(req_field) && eff_addr == $past(req_field)));

    p_illegal_done_r9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && eff_addr == 32'd0));

    p_req_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind opf_unit opf_unit_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_field (req_field),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .done      (done),
    .eff_addr  (eff_addr),
    .illegal   (illegal)
);

// File: tb/test_opf_unit.sv
`timescale 1ns/1ps
module test_opf_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [2:0]  req_reg = '0;
    logic [2:0]  req_index = '0;
    logic [1:0]  req_scale = '0;
    logic        req_wide = 1'b0;
    logic [31:0] req_field = '0;
    logic [255:0] reg_file;
    logic [31:0] stack_ptr = 32'h0000_FFF0;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] operand;
    logic [31:0] eff_addr;
    logic        illegal;

    typedef struct {
        logic [31:0] opv;
        logic [31:0] ea;
        logic        bad;
        int          reads;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          failures = 0;
    int          pushed = 0;
    int          popped = 0;
    int          rd_total = 0;
    int          rd_base = 0;
    int          wait_cfg = 0;
    int          wcnt = 0;
    int          cycles = 0;
    logic        pend_prev = 1'b0;
    logic [31:0] addr_prev = '0;
    logic [31:0] regs [8];

    always #10 clk = ~clk;

    opf_unit i_opf_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_reg(req_reg), .req_index(req_index), .req_scale(req_scale),
        .req_wide(req_wide), .req_field(req_field), .reg_file(reg_file),
        .stack_ptr(stack_ptr), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .operand(operand),
        .eff_addr(eff_addr), .illegal(illegal)
    );

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 32'h0100_0100 * (i + 1) + 32'h40 * i;
    end
    always_comb begin
        for (int i = 0; i < 8; i++) reg_file[i*32 +: 32] = regs[i];
    end

    function automatic logic [31:0] memf(logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model with configurable wait states and hold check
    always @(negedge clk) begin
        if (pend_prev) begin
            check(mem_req === 1'b1 && mem_addr === addr_prev, "R10 request held", mem_addr, addr_prev);
        end
        pend_prev = 1'b0;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wcnt == 0) begin
                mem_ack   = 1'b1;
                mem_rdata = memf(mem_addr);
                wcnt      = wait_cfg;
            end else begin
                wcnt--;
                pend_prev = 1'b1;
                addr_prev = mem_addr;
            end
        end else begin
            wcnt = wait_cfg;
        end
    end

    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack) rd_total++;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11 unexpected done", operand, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                popped++;
                check(operand === e.opv, {e.tag, " operand"}, operand, e.opv);
                check(eff_addr === e.ea, {e.tag, " eff_addr"}, eff_addr, e.ea);
                check(illegal === e.bad, {e.tag, " illegal"}, {31'd0, illegal}, {31'd0, e.bad});
                check((rd_total - rd_base) == e.reads, {e.tag, " read count"},
                      rd_total - rd_base, e.reads);
            end
            rd_base = rd_total;
        end
    end

    task automatic issue(input logic [2:0] m, input logic [2:0] rs, input logic [2:0] ix,
                         input logic [1:0] sc, input logic wd, input logic [31:0] f,
                         input int wt, input string tag);
        exp_t e;
        logic [31:0] d;
        e.bad = 1'b0; e.opv = '0; e.ea = '0; e.reads = 0; e.tag = tag;
        d = wd ? f : {{24{f[7]}}, f[7:0]};
        case (m)
            3'd0: e.opv = f;
            3'd1: begin e.ea = f; e.opv = memf(f); e.reads = 1; end
            3'd2: begin e.ea = memf(f); e.opv = memf(memf(f)); e.reads = 2; end
            3'd3: e.opv = regs[rs];
            3'd4: begin e.ea = regs[rs]; e.opv = memf(regs[rs]); e.reads = 1; end
            3'd5: begin
                e.ea = regs[rs] + (regs[ix] << sc) + d;
                e.opv = memf(e.ea); e.reads = 1;
            end
            3'd6: begin e.ea = stack_ptr; e.opv = memf(stack_ptr); e.reads = 1; end
            default: e.bad = 1'b1;
        endcase
        @(negedge clk);
        while (busy) @(negedge clk);
        wait_cfg = wt;
        wcnt = wt;
        sb.push_back(e);
        pushed++;
        req_mode = m; req_reg = rs; req_index = ix; req_scale = sc; req_wide = wd; req_field = f;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R12 reset done", {31'd0, done}, 32'd0);
        check(mem_req === 1'b0, "R12 reset mem_req", {31'd0, mem_req}, 32'd0);
        check(busy === 1'b0, "R12 reset busy", {31'd0, busy}, 32'd0);

        issue(3'd0, 3'd0, 3'd0, 2'd0, 1'b0, 32'hDEAD_BEEF, 0, "R1 immediate");
        issue(3'd3, 3'd6, 3'd0, 2'd0, 1'b0, 32'h0, 0, "R4 register");
        issue(3'd1, 3'd0, 3'd0, 2'd0, 1'b0, 32'h0000_1234, 0, "R2 direct");
        issue(3'd1, 3'd0, 3'd0, 2'd0, 1'b0, 32'h00AB_0010, 4, "R2 direct wait");
        issue(3'd2, 3'd0, 3'd0, 2'd0, 1'b0, 32'h0000_4444, 2, "R3 indirect");
        issue(3'd2, 3'd0, 3'd0, 2'd0, 1'b0, 32'h7700_0008, 0, "R3 indirect nowait");
        issue(3'd4, 3'd3, 3'd0, 2'd0, 1'b0, 32'h0, 1, "R5 register-indirect");
        issue(3'd5, 3'd2, 3'd5, 2'd3, 1'b0, 32'h1234_56F0, 0, "R6 R7 disp scale8 short");
        issue(3'd5, 3'd7, 3'd1, 2'd0, 1'b1, 32'h8000_0001, 1, "R7 disp wide");
        issue(3'd5, 3'd0, 3'd4, 2'd1, 1'b0, 32'hFFFF_FF7F, 0, "R6 disp scale2");
        issue(3'd5, 3'd1, 3'd1, 2'd2, 1'b0, 32'h0000_0080, 2, "R6 R7 disp scale4 negative");
        issue(3'd6, 3'd0, 3'd0, 2'd0, 1'b0, 32'h0, 3, "R8 stack");
        issue(3'd7, 3'd0, 3'd0, 2'd0, 1'b0, 32'h5555_AAAA, 0, "R9 illegal");

        // R11: a request while busy must be ignored
        fork
            issue(3'd1, 3'd0, 3'd0, 2'd0, 1'b0, 32'h0000_2020, 6, "R11 direct under intrusion");
            begin
                repeat (4) @(negedge clk);
                check(busy === 1'b1, "R11 busy during read", {31'd0, busy}, 32'd1);
                req_mode = 3'd0; req_field = 32'h0BAD_0BAD; req_valid = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        repeat (4) @(negedge clk);
        check(sb.size() == 0 && pushed == popped, "R11 result count", popped, pushed);
        check(operand === memf(32'h0000_2020), "R11 operand unchanged", operand, memf(32'h0000_2020));
        check(done === 1'b0 && mem_req === 1'b0, "R11 idle after ignore", {31'd0, done}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule